// File: doc/BRIEF.md
# Keyboard Controller Gate-Sequence Trap

This block watches host I/O cycles aimed at a legacy keyboard controller. The controller has a data port and a command/status port. The block follows the multi-cycle gate-control command sequence the host sends to that controller. For every observed cycle it gives two verdicts:

- whether the cycle may go on to the real controller (forward enable);
- whether a system management interrupt is requested.

While a sequence is open, a pending flag is held high. Cycles that stray from the expected sequence close it. For each kind of stray cycle, a trap-configuration bit of its own decides whether that cycle is held back and an interrupt raised instead. A separate exit bit adds an interrupt every time an open sequence closes.

States and transitions:

- ST_IDLE: a command-port write of D1h moves the block to ST_GATE1. Any other cycle leaves it in ST_IDLE.
- ST_GATE1:
  - a repeated D1h command write keeps the block in ST_GATE1;
  - a data-port write moves it to ST_GATE2;
  - any other command write, or a data-port read, returns it to ST_IDLE.
- ST_GATE2:
  - an FFh command write is the proper close and returns the block to ST_IDLE;
  - any other command write, a data-port write or a data-port read returns it to ST_IDLE as an improper close.
- In both gate states, a command-port read, or a cycle to an unrelated address, leaves the state unchanged.

Top module: `kbc_gate_trap`

## Requirements
- R1: While reset is high and after it is released, pending and irq_pulse are 0. fwd_en is 0 whenever cyc_valid is 0.
- R2: In ST_IDLE every valid cycle is forwarded and raises no interrupt. A write of D1h to the command port moves the block to ST_GATE1, and pending becomes 1 at the next clock edge.
- R3: In ST_GATE1 a further D1h command write keeps the block in ST_GATE1 with pending at 1. That write is forwarded and raises no interrupt, even with every trap bit and cfg_exit_irq set.
- R4: In ST_GATE1 a data-port write moves the block to ST_GATE2. The write is forwarded and raises no interrupt from the trap bits.
- R5: In ST_GATE1 a command write of any value other than D1h returns the block to ST_IDLE. If cfg_trap bit 3 is 1, the cycle is held back and an interrupt is raised. If bit 3 is 0, the cycle is forwarded with no interrupt from that bit.
- R6: In either gate state a data-port read returns the block to ST_IDLE. cfg_trap bit 0 decides the outcome: 1 holds the cycle back and raises an interrupt, 0 forwards it.
- R7: In either gate state a command-port read leaves the state and pending unchanged and is always forwarded. It raises an interrupt exactly when cfg_trap bit 2 is 1.
- R8: In ST_GATE2 a command write of FFh returns the block to ST_IDLE and is always forwarded. It raises an interrupt only through cfg_exit_irq.
- R9: In ST_GATE2 a command write of any value other than FFh returns the block to ST_IDLE. cfg_trap bit 3 decides holding back and the interrupt.
- R10: In ST_GATE2 a data-port write returns the block to ST_IDLE. cfg_trap bit 1 decides holding back and the interrupt.
- R11: Every return from a gate state to ST_IDLE raises an interrupt when cfg_exit_irq is 1. This adds to any interrupt from a trap bit and applies to the proper close as well.
- R12: In either gate state a cycle to an address other than the two ports is forwarded, raises no interrupt, and leaves the state unchanged.
- R13: fwd_en is combinational and valid in the same cycle as cyc_valid. irq_pulse is high for exactly the one cycle after the clock edge that samples the triggering cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_valid | input | 1 | One observed I/O cycle is present this clock |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cyc_addr | input | ADDR_W (16) | I/O port address of the cycle |
| cyc_wdata | input | 8 | Write data byte |
| cfg_trap | input | 4 | Trap bits: 0 data read, 1 data write, 2 command read interrupt, 3 command write |
| cfg_exit_irq | input | 1 | Raise an interrupt on every return to ST_IDLE |
| fwd_en | output | 1 | Pass the current cycle to the keyboard controller |
| irq_pulse | output | 1 | One-cycle interrupt request |
| pending | output | 1 | A gate sequence is open |

## Verification
The bench drives every exit from every gate state with its deciding trap bit set and cleared. A block that picked the wrong bit for a case would forward a cycle it should hold back, or hold back one it should forward. The repeated D1h write and the proper FFh close are driven with all trap bits set. Applying a trap bit there would show up as a held-back cycle or a stray interrupt. Command reads and unrelated addresses are followed by a transition that only the correct state accepts, so a block that wrongly left its state would show a wrong pending value or wrong forwarding. Exit interrupts are checked on proper and improper closes alike, and the interrupt is checked to drop after one cycle.

// File: rtl/kbc_trap_pkg.sv
package kbc_trap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GATE1 = 2'd1,
        ST_GATE2 = 2'd2
    } trap_state_e;

    typedef enum logic [2:0] {
        EV_NONE         = 3'd0,
        EV_CMD_WR_GATE  = 3'd1,
        EV_CMD_WR_END   = 3'd2,
        EV_CMD_WR_OTHER = 3'd3,
        EV_CMD_RD       = 3'd4,
        EV_DAT_WR       = 3'd5,
        EV_DAT_RD       = 3'd6,
        EV_FOREIGN      = 3'd7
    } cyc_event_e;

    localparam int unsigned TRAP_W      = 4;
    localparam int unsigned TRAP_DAT_RD = 0;
    localparam int unsigned TRAP_DAT_WR = 1;
    localparam int unsigned TRAP_CMD_RD = 2;
    localparam int unsigned TRAP_CMD_WR = 3;

    localparam logic [7:0] GATE_CMD = 8'hD1;
    localparam logic [7:0] END_CMD  = 8'hFF;

    typedef struct packed {
        logic fwd;
        logic irq;
        logic leave;
    } verdict_t;

endpackage

// File: rtl/kbc_cycle_decode.sv
module kbc_cycle_decode
    import kbc_trap_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0060,
    parameter logic [ADDR_W-1:0] CMD_PORT  = 16'h0064
) (
    input  logic              valid_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output cyc_event_e        event_o
);

    logic hit_data;
    logic hit_cmd;

    assign hit_data = (addr_i == DATA_PORT);
    assign hit_cmd  = (addr_i == CMD_PORT);

    always_comb begin
        event_o = EV_NONE;
        if (valid_i) begin
            if (hit_cmd) begin
                if (!write_i) begin
                    event_o = EV_CMD_RD;
                end else if (wdata_i == GATE_CMD) begin
                    event_o = EV_CMD_WR_GATE;
                end else if (wdata_i == END_CMD) begin
                    event_o = EV_CMD_WR_END;
                end else begin
                    event_o = EV_CMD_WR_OTHER;
                end
            end else if (hit_data) begin
                event_o = write_i ? EV_DAT_WR : EV_DAT_RD;
            end else begin
                event_o = EV_FOREIGN;
            end
        end
    end

endmodule

// File: rtl/kbc_trap_fsm.sv
module kbc_trap_fsm
    import kbc_trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cyc_event_e        event_i,
    input  logic [TRAP_W-1:0] trap_i,
    input  logic              exit_irq_i,
    output trap_state_e       state_o,
    output logic              fwd_o,
    output logic              irq_req_o
);

    trap_state_e state_q;
    trap_state_e state_d;
    verdict_t    vd;

    function automatic verdict_t trap_exit(input logic bit_set);
        verdict_t v;
        v.fwd   = !bit_set;
        v.irq   = bit_set;
        v.leave = 1'b1;
        return v;
    endfunction

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (event_i == EV_CMD_WR_GATE) begin
                    state_d = ST_GATE1;
                end
            end
            ST_GATE1: begin
                unique case (event_i)
                    EV_DAT_WR:                        state_d = ST_GATE2;
                    EV_CMD_WR_END, EV_CMD_WR_OTHER,
                    EV_DAT_RD:                        state_d = ST_IDLE;
                    default:                          state_d = ST_GATE1;
                endcase
            end
            ST_GATE2: begin
                unique case (event_i)
                    EV_CMD_WR_GATE, EV_CMD_WR_END,
                    EV_CMD_WR_OTHER, EV_DAT_WR,
                    EV_DAT_RD:                        state_d = ST_IDLE;
                    default:                          state_d = ST_GATE2;
                endcase
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        vd = '{fwd: 1'b1, irq: 1'b0, leave: 1'b0};
        unique case (state_q)
            ST_IDLE: begin
                vd = '{fwd: 1'b1, irq: 1'b0, leave: 1'b0};
            end
            ST_GATE1: begin
                unique case (event_i)
                    EV_CMD_WR_END, EV_CMD_WR_OTHER: vd = trap_exit(trap_i[TRAP_CMD_WR]);
                    EV_DAT_RD:                      vd = trap_exit(trap_i[TRAP_DAT_RD]);
                    EV_CMD_RD:                      vd.irq = trap_i[TRAP_CMD_RD];
                    default:                        vd = '{fwd: 1'b1, irq: 1'b0, leave: 1'b0};
                endcase
            end
            ST_GATE2: begin
                unique case (event_i)
                    EV_CMD_WR_END:                   vd = '{fwd: 1'b1, irq: 1'b0, leave: 1'b1};
                    EV_CMD_WR_GATE, EV_CMD_WR_OTHER: vd = trap_exit(trap_i[TRAP_CMD_WR]);
                    EV_DAT_WR:                       vd = trap_exit(trap_i[TRAP_DAT_WR]);
                    EV_DAT_RD:                       vd = trap_exit(trap_i[TRAP_DAT_RD]);
                    EV_CMD_RD:                       vd.irq = trap_i[TRAP_CMD_RD];
                    default:                         vd = '{fwd: 1'b1, irq: 1'b0, leave: 1'b0};
                endcase
            end
            default: vd = '{fwd: 1'b1, irq: 1'b0, leave: 1'b0};
        endcase
    end

    assign state_o   = state_q;
    assign fwd_o     = vd.fwd;
    assign irq_req_o = vd.irq | (vd.leave & exit_irq_i);

endmodule

// File: rtl/kbc_irq_gen.sv
module kbc_irq_gen (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic pulse_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= req_i;
        end
    end

endmodule

// File: rtl/kbc_gate_trap.sv
module kbc_gate_trap
    import kbc_trap_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0060,
    parameter logic [ADDR_W-1:0] CMD_PORT  = 16'h0064
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_valid,
    input  logic              cyc_write,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [7:0]        cyc_wdata,
    input  logic [TRAP_W-1:0] cfg_trap,
    input  logic              cfg_exit_irq,
    output logic              fwd_en,
    output logic              irq_pulse,
    output logic              pending
);

    cyc_event_e  ev;
    trap_state_e state;
    logic        fwd_raw;
    logic        irq_req;

    kbc_cycle_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_PORT (DATA_PORT),
        .CMD_PORT  (CMD_PORT)
    ) decode_i (
        .valid_i (cyc_valid),
        .write_i (cyc_write),
        .addr_i  (cyc_addr),
        .wdata_i (cyc_wdata),
        .event_o (ev)
    );

    kbc_trap_fsm fsm_i (
        .clk        (clk),
        .rst        (rst),
        .event_i    (ev),
        .trap_i     (cfg_trap),
        .exit_irq_i (cfg_exit_irq),
        .state_o    (state),
        .fwd_o      (fwd_raw),
        .irq_req_o  (irq_req)
    );

    kbc_irq_gen irq_i (
        .clk     (clk),
        .rst     (rst),
        .req_i   (irq_req),
        .pulse_o (irq_pulse)
    );

    assign fwd_en  = cyc_valid & fwd_raw;
    assign pending = (state != ST_IDLE);

endmodule

// File: rtl/kbc_gate_trap_chk.sv
module kbc_gate_trap_chk #(
    parameter int unsigned ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0060,
    parameter logic [ADDR_W-1:0] CMD_PORT  = 16'h0064
) (
    input logic              clk,
    input logic              rst,
    input logic              cyc_valid,
    input logic              cyc_write,
    input logic [ADDR_W-1:0] cyc_addr,
    input logic [7:0]        cyc_wdata,
    input logic              cfg_exit_irq,
    input logic              fwd_en,
    input logic              irq_pulse,
    input logic              pending
);

    logic cmd_rd;
    logic gate_wr;
    assign cmd_rd  = cyc_valid && !cyc_write && (cyc_addr == CMD_PORT);
    assign gate_wr = cyc_valid && cyc_write && (cyc_addr == CMD_PORT) && (cyc_wdata == 8'hD1);

    assert_fwd_needs_valid_R13: assert property (@(posedge clk) disable iff (rst)
        fwd_en |-> cyc_valid);

    assert_irq_after_cycle_R13: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> $past(cyc_valid));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (!pending && cyc_valid) |=> !irq_pulse);

    assert_enter_on_gate_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> $past(gate_wr));

    assert_cmd_read_fwd_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_rd |-> fwd_en);

    assert_cmd_read_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (pending && cmd_rd) |=> pending);

    assert_exit_irq_R11: assert property (@(posedge clk) disable iff (rst)
        ($fell(pending) && $past(cfg_exit_irq)) |-> irq_pulse);

endmodule

bind kbc_gate_trap kbc_gate_trap_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_PORT (DATA_PORT),
    .CMD_PORT  (CMD_PORT)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .cyc_valid    (cyc_valid),
    .cyc_write    (cyc_write),
    .cyc_addr     (cyc_addr),
    .cyc_wdata    (cyc_wdata),
    .cfg_exit_irq (cfg_exit_irq),
    .fwd_en       (fwd_en),
    .irq_pulse    (irq_pulse),
    .pending      (pending)
);

// File: tb/kbc_gate_trap_tb_top.sv
`timescale 1ns/1ps
module kbc_gate_trap_tb_top;

    localparam logic [15:0] DP = 16'h0060;
    localparam logic [15:0] CP = 16'h0064;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_valid = 1'b0;
    logic        cyc_write = 1'b0;
    logic [15:0] cyc_addr = '0;
    logic [7:0]  cyc_wdata = '0;
    logic [3:0]  cfg_trap = '0;
    logic        cfg_exit_irq = 1'b0;
    logic        fwd_en;
    logic        irq_pulse;
    logic        pending;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    logic fwd_s, irq_s, pend_s;

    always #4 clk = ~clk;

    kbc_gate_trap dut_i (
        .clk          (clk),
        .rst          (rst),
        .cyc_valid    (cyc_valid),
        .cyc_write    (cyc_write),
        .cyc_addr     (cyc_addr),
        .cyc_wdata    (cyc_wdata),
        .cfg_trap     (cfg_trap),
        .cfg_exit_irq (cfg_exit_irq),
        .fwd_en       (fwd_en),
        .irq_pulse    (irq_pulse),
        .pending      (pending)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // One cycle: fwd sampled mid-cycle, irq and pending sampled after the edge.
    task automatic cyc(input logic wr, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cyc_valid = 1'b1; cyc_write = wr; cyc_addr = a; cyc_wdata = d;
        #1 fwd_s = fwd_en;
        @(negedge clk);
        cyc_valid = 1'b0;
        irq_s  = irq_pulse;
        pend_s = pending;
    endtask

    task automatic expect3(input string tag, input logic ef, input logic ei, input logic ep);
        chk(tag, "fwd_en", fwd_s, ef);
        chk(tag, "irq_pulse", irq_s, ei);
        chk(tag, "pending", pend_s, ep);
    endtask

    task automatic set_cfg(input logic [3:0] t, input logic x);
        cfg_trap = t; cfg_exit_irq = x;
    endtask

    task automatic enter_g1();
        cyc(1'b1, CP, 8'hD1);
    endtask

    task automatic enter_g2();
        cyc(1'b1, CP, 8'hD1);
        cyc(1'b1, DP, 8'h00);
    endtask

    task automatic to_idle();
        set_cfg(4'h0, 1'b0);
        cyc(1'b0, DP, 8'h00);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "pending in reset", pending, 1'b0);
        chk("R1", "irq in reset", irq_pulse, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "pending after reset", pending, 1'b0);
        chk("R1", "irq after reset", irq_pulse, 1'b0);
        chk("R1", "fwd without valid", fwd_en, 1'b0);
    endtask

    task automatic t_idle();
        set_cfg(4'hF, 1'b1);
        cyc(1'b1, CP, 8'h20); expect3("R2", 1, 0, 0);
        cyc(1'b0, DP, 8'h00); expect3("R2", 1, 0, 0);
        cyc(1'b1, DP, 8'h55); expect3("R2", 1, 0, 0);
        cyc(1'b1, CP, 8'hD1); expect3("R2", 1, 0, 1);
        to_idle();
    endtask

    task automatic t_g1_repeat();
        set_cfg(4'hF, 1'b1);
        enter_g1();
        cyc(1'b1, CP, 8'hD1); expect3("R3", 1, 0, 1);
        to_idle();
    endtask

    task automatic t_g1_to_g2();
        set_cfg(4'hF, 1'b0);
        enter_g1();
        cyc(1'b1, DP, 8'h00); expect3("R4", 1, 0, 1);
        cyc(1'b1, CP, 8'hFF); expect3("R8", 1, 0, 0);
    endtask

    task automatic t_g1_cmd_other();
        set_cfg(4'h8, 1'b0);
        enter_g1();
        cyc(1'b1, CP, 8'h20); expect3("R5", 0, 1, 0);
        set_cfg(4'h7, 1'b0);
        enter_g1();
        cyc(1'b1, CP, 8'hFF); expect3("R5", 1, 0, 0);
    endtask

    task automatic t_data_read();
        set_cfg(4'h1, 1'b0);
        enter_g1();
        cyc(1'b0, DP, 8'h00); expect3("R6", 0, 1, 0);
        set_cfg(4'hE, 1'b0);
        enter_g2();
        cyc(1'b0, DP, 8'h00); expect3("R6", 1, 0, 0);
        set_cfg(4'h1, 1'b0);
        enter_g2();
        cyc(1'b0, DP, 8'h00); expect3("R6", 0, 1, 0);
    endtask

    task automatic t_cmd_read();
        set_cfg(4'hC, 1'b0);
        enter_g1();
        cyc(1'b0, CP, 8'h00); expect3("R7", 1, 1, 1);
        set_cfg(4'h8, 1'b0);
        cyc(1'b0, CP, 8'h00); expect3("R7", 1, 0, 1);
        set_cfg(4'hF, 1'b0);
        cyc(1'b1, DP, 8'h00); expect3("R7", 1, 0, 1);
        set_cfg(4'hC, 1'b0);
        cyc(1'b0, CP, 8'h00); expect3("R7", 1, 1, 1);
        cyc(1'b1, CP, 8'hFF); expect3("R7", 1, 0, 0);
    endtask

    task automatic t_g2_end();
        set_cfg(4'hF, 1'b0);
        enter_g2();
        cyc(1'b1, CP, 8'hFF); expect3("R8", 1, 0, 0);
        set_cfg(4'hF, 1'b1);
        enter_g2();
        cyc(1'b1, CP, 8'hFF); expect3("R8", 1, 1, 0);
    endtask

    task automatic t_g2_cmd_other();
        set_cfg(4'h8, 1'b0);
        enter_g2();
        cyc(1'b1, CP, 8'hD1); expect3("R9", 0, 1, 0);
        set_cfg(4'h7, 1'b0);
        enter_g2();
        cyc(1'b1, CP, 8'h3C); expect3("R9", 1, 0, 0);
    endtask

    task automatic t_g2_data_wr();
        set_cfg(4'h2, 1'b0);
        enter_g2();
        cyc(1'b1, DP, 8'hA5); expect3("R10", 0, 1, 0);
        set_cfg(4'hD, 1'b0);
        enter_g2();
        cyc(1'b1, DP, 8'hA5); expect3("R10", 1, 0, 0);
    endtask

    task automatic t_exit_irq();
        set_cfg(4'h0, 1'b1);
        enter_g1();
        cyc(1'b0, DP, 8'h00); expect3("R11", 1, 1, 0);
        enter_g2();
        cyc(1'b1, DP, 8'h00); expect3("R11", 1, 1, 0);
        set_cfg(4'h2, 1'b1);
        enter_g2();
        cyc(1'b1, DP, 8'h00); expect3("R11", 0, 1, 0);
    endtask

    task automatic t_foreign();
        set_cfg(4'hF, 1'b1);
        enter_g1();
        cyc(1'b1, 16'h0061, 8'h00); expect3("R12", 1, 0, 1);
        cyc(1'b0, 16'h0080, 8'h00); expect3("R12", 1, 0, 1);
        cyc(1'b1, DP, 8'h00);       expect3("R12", 1, 0, 1);
        cyc(1'b1, 16'h0065, 8'hFF); expect3("R12", 1, 0, 1);
        set_cfg(4'hF, 1'b0);
        cyc(1'b1, CP, 8'hFF);       expect3("R12", 1, 0, 0);
    endtask

    task automatic t_pulse();
        set_cfg(4'h8, 1'b0);
        enter_g1();
        cyc(1'b1, CP, 8'h00); expect3("R13", 0, 1, 0);
        @(negedge clk);
        chk("R13", "irq one cycle", irq_pulse, 1'b0);
        chk("R13", "fwd drops with valid", fwd_en, 1'b0);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_g1_repeat();
        t_g1_to_g2();
        t_g1_cmd_other();
        t_data_read();
        t_cmd_read();
        t_g2_end();
        t_g2_cmd_other();
        t_g2_data_wr();
        t_exit_irq();
        t_foreign();
        t_pulse();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule